// File: doc/BRIEF.md
# Multi-Mode Acquisition Trigger Controller

This block decides when a data acquisition should begin. It watches a stream of analog samples, each marked by a valid strobe, and one asynchronous digital line. A small bank of write-only configuration registers selects one of three detectors: a level crossing on the analog stream, entry of the analog value into a window, or a transition on the digital line. The same registers hold the crossing direction, the level, the two window bounds, a timeout, the post-trigger action and the interrupt line to use.

The host programs the settings and then writes the arm command. The block then waits. The wait ends when the selected detector fires or when the timeout runs out, whichever comes first. On a real trigger it issues a one-cycle acquisition-start pulse. If the post-trigger action is set to interrupt, it also raises one of 32 interrupt lines, and that line stays high until the host clears it. A status output shows whether the last wait ended by timeout.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `acq_start`, `timed_out` and all bits of `irq_o` are low.
- R2: Register map, written with `cfg_we`:
  - Address 0 is the control word. Bits [1:0] select the detector: 0 is the analog edge, 1 is the analog window, 2 is the digital edge, and 3 never fires. Bit 2 set means falling, clear means rising. Bit 3 enables the interrupt action. Bits [8:4] give the interrupt line.
  - Address 1 holds the level, address 2 the window low bound, address 3 the window high bound and address 4 the timeout.
  - Address 5 is the command register. Bit 0 arms the block, which sets `busy`. Bit 1 clears all interrupt lines.
- R3: A rising analog edge fires on a valid sample strictly above the level when the stored previous sample was strictly below it. A sample equal to the level never counts as a crossing.
- R4: A falling analog edge fires on a valid sample strictly below the level when the stored previous sample was strictly above it.
- R5: The first valid sample after arming only loads the previous-sample register and can never fire an edge trigger.
- R6: The window detector fires on the first valid sample strictly greater than the low bound and strictly less than the high bound. If the low bound is not below the high bound, it never fires.
- R7: The digital input passes through a two-flop synchroniser. A transition in the programmed direction makes `acq_start` high in the cycle after the third rising clock edge that follows the input change.
- R8: Only the selected detector can end the wait. Samples with `smp_valid` low are ignored.
- R9: With timeout value T>0, if no trigger has fired, the wait ends at the T-th rising edge after the arm edge. At that point `busy` falls, `timed_out` rises and no `acq_start` is issued. T=0 waits forever. Arming clears `timed_out`.
- R10: A trigger issues `acq_start` for exactly one cycle, in the cycle after the edge at which the trigger is sampled. If a trigger and timeout expiry fall on the same edge, the trigger wins.
- R11: With the interrupt action enabled, a trigger sets `irq_o[line]`. That bit stays high until a clear command. With the action disabled, no interrupt bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| smp_valid | input | 1 | Analog sample valid |
| smp_data | input | 16 | Analog sample, unsigned |
| dig_in | input | 1 | Asynchronous digital trigger input |
| busy | output | 1 | Armed and waiting |
| timed_out | output | 1 | Last wait ended by timeout |
| acq_start | output | 1 | One-cycle acquisition start pulse |
| irq_o | output | 32 | Sticky interrupt lines |

## Verification
Each analog result is due one clock edge after the sample that causes it. The bench therefore presents each sample at a falling clock edge and reads `acq_start` at the next falling edge. A digital transition needs three rising edges before it shows, so the bench checks that `acq_start` is still low at the first two falling edges and high at the third. The timeout edge is counted from the arm write: `busy` is checked high at each of the first T-1 falling edges and low, with `timed_out` set, at the T-th. The tie case places the crossing sample on exactly that edge.

// File: rtl/trig_pkg.sv
// Shared types and register addresses for the acquisition trigger controller.
package trig_pkg;
    typedef enum logic [1:0] {
        TT_AEDGE = 2'd0,
        TT_WIN   = 2'd1,
        TT_DEDGE = 2'd2,
        TT_OFF   = 2'd3
    } trig_type_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } trig_state_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_LEVEL = 3'd1;
    localparam logic [2:0] A_WLO   = 3'd2;
    localparam logic [2:0] A_WHI   = 3'd3;
    localparam logic [2:0] A_TMO   = 3'd4;
    localparam logic [2:0] A_CMD   = 3'd5;
endpackage

// File: rtl/trig_regs.sv
// Configuration register bank.
// Holds the trigger settings and decodes the command register into one-cycle
// arm and interrupt-clear strobes. Assumes DW <= 32 and 9 + IW <= 32.
module trig_regs
    import trig_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    output trig_type_e    ttype,
    output logic          falling,
    output logic          irq_en,
    output logic [IW-1:0] irq_sel,
    output logic [DW-1:0] level,
    output logic [DW-1:0] win_lo,
    output logic [DW-1:0] win_hi,
    output logic [TW-1:0] tmo,
    output logic          arm,
    output logic          irq_clr
);
    // Store the settings on a write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ttype   <= TT_AEDGE;
            falling <= 1'b0;
            irq_en  <= 1'b0;
            irq_sel <= '0;
            level   <= '0;
            win_lo  <= '0;
            win_hi  <= '0;
            tmo     <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    ttype   <= trig_type_e'(wdata[1:0]);
                    falling <= wdata[2];
                    irq_en  <= wdata[3];
                    irq_sel <= wdata[4 +: IW];
                end
                A_LEVEL: level  <= wdata[DW-1:0];
                A_WLO:   win_lo <= wdata[DW-1:0];
                A_WHI:   win_hi <= wdata[DW-1:0];
                A_TMO:   tmo    <= wdata[TW-1:0];
                default: ;
            endcase
        end
    end

    // Decode the command strobes straight from the write.
    always_comb begin
        arm     = we && (addr == A_CMD) && wdata[0];
        irq_clr = we && (addr == A_CMD) && wdata[1];
    end
endmodule

// File: rtl/trig_detect.sv
// Trigger detectors.
// Holds the analog edge, analog window and digital edge detectors and gives
// the fire output of the one selected. The analog detectors act only on valid
// samples while active. The digital input is assumed asynchronous and is
// synchronised here.
module trig_detect
    import trig_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          active,
    input  trig_type_e    ttype,
    input  logic          falling,
    input  logic [DW-1:0] level,
    input  logic [DW-1:0] win_lo,
    input  logic [DW-1:0] win_hi,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          dig_in,
    output logic          fire
);
    logic [DW-1:0] prev_q;
    logic          have_prev_q;
    logic [1:0]    sync_q;
    logic          dig_prev_q;
    logic          edge_hit, win_hit, dig_hit;

    // Keep the previous valid sample seen since the last arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (arm) begin
            have_prev_q <= 1'b0;
        end else if (active && smp_valid) begin
            prev_q      <= smp_data;
            have_prev_q <= 1'b1;
        end
    end

    // Two-flop synchroniser plus one delayed copy for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q     <= '0;
            dig_prev_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[0], dig_in};
            dig_prev_q <= sync_q[1];
        end
    end

    // Evaluate each detector and select the programmed one.
    always_comb begin
        if (falling) edge_hit = have_prev_q && (prev_q > level) && (smp_data < level);
        else         edge_hit = have_prev_q && (prev_q < level) && (smp_data > level);
        win_hit = (smp_data > win_lo) && (smp_data < win_hi);
        if (falling) dig_hit = !sync_q[1] && dig_prev_q;
        else         dig_hit = sync_q[1] && !dig_prev_q;
        case (ttype)
            TT_AEDGE: fire = active && smp_valid && edge_hit;
            TT_WIN:   fire = active && smp_valid && win_hit;
            TT_DEDGE: fire = active && dig_hit;
            default:  fire = 1'b0;
        endcase
    end

    // R5: an edge fire needs a valid sample stored since arming.
    a_r5_first_sample_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (arm) |=> !(fire && ttype == TT_AEDGE));
endmodule

// File: rtl/trig_timer.sv
// Wait timeout counter.
// Loads the limit on arm and counts down while active. It flags expiry on the
// cycle whose count is one. A zero limit disables expiry.
module trig_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          active,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;
    logic          lim_nz_q;

    // Load on arm, then count down toward one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            lim_nz_q <= 1'b0;
        end else if (arm) begin
            cnt_q    <= limit;
            lim_nz_q <= |limit;
        end else if (active && lim_nz_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag expiry when the last counted cycle is reached.
    always_comb expire = active && lim_nz_q && (cnt_q == TW'(1)) && !arm;

    // R9: the count falls by exactly one per waiting cycle.
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !arm && lim_nz_q && cnt_q > TW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/acq_trig_ctrl.sv
// Acquisition trigger controller, top level.
// Arming starts a wait. The wait ends on the selected trigger or on timeout;
// a trigger wins a tie. On a trigger it pulses acq_start and, if enabled, sets
// a sticky interrupt bit. Assumes a single clock domain except dig_in.
module acq_trig_ctrl
    import trig_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TW   = 32,
    parameter int NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    input  logic            smp_valid,
    input  logic [DW-1:0]   smp_data,
    input  logic            dig_in,
    output logic            busy,
    output logic            timed_out,
    output logic            acq_start,
    output logic [NIRQ-1:0] irq_o
);
    localparam int IW = $clog2(NIRQ);

    trig_type_e    ttype;
    logic          falling, irq_en, arm, irq_clr, fire, expire, hit;
    logic [IW-1:0] irq_sel;
    logic [DW-1:0] level, win_lo, win_hi;
    logic [TW-1:0] tmo;
    trig_state_e   state_q;
    logic          active;

    trig_regs #(.DW(DW), .TW(TW), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ttype(ttype), .falling(falling), .irq_en(irq_en), .irq_sel(irq_sel),
        .level(level), .win_lo(win_lo), .win_hi(win_hi), .tmo(tmo),
        .arm(arm), .irq_clr(irq_clr)
    );

    trig_detect #(.DW(DW)) u_detect (
        .clk(clk), .rst_n(rst_n), .arm(arm), .active(active), .ttype(ttype),
        .falling(falling), .level(level), .win_lo(win_lo), .win_hi(win_hi),
        .smp_valid(smp_valid), .smp_data(smp_data), .dig_in(dig_in), .fire(fire)
    );

    trig_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .active(active), .limit(tmo),
        .expire(expire)
    );

    // Trigger accepted this cycle; a concurrent arm restarts the wait instead.
    always_comb begin
        active = (state_q == ST_WAIT);
        hit    = active && fire && !arm;
    end

    // Wait state sequencing and the status flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            timed_out <= 1'b0;
            acq_start <= 1'b0;
        end else begin
            acq_start <= hit;
            if (arm) begin
                state_q   <= ST_WAIT;
                timed_out <= 1'b0;
            end else if (hit) begin
                state_q <= ST_IDLE;
            end else if (expire) begin
                state_q   <= ST_IDLE;
                timed_out <= 1'b1;
            end
        end
    end

    always_comb busy = active;

    // One sticky flop per interrupt line.
    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
        always_ff @(posedge clk) begin
            if (!rst_n)                                     irq_o[i] <= 1'b0;
            else if (hit && irq_en && irq_sel == IW'(i))    irq_o[i] <= 1'b1;
            else if (irq_clr)                               irq_o[i] <= 1'b0;
        end
    end

    // R10: the start pulse lasts one cycle.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !acq_start);
    // R10: a start only follows a waiting cycle.
    a_r10_start_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |-> $past(state_q == ST_WAIT));
    // R9: a timeout exit never starts acquisition.
    a_r9_timeout_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out) |-> !acq_start);
    // R11: interrupt bits only drop after a clear command.
    a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_clr |=> ((irq_o & $past(irq_o)) == $past(irq_o)));
endmodule

// File: tb/acq_trig_ctrl_bench.sv
module acq_trig_ctrl_bench;
    import trig_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        dig_in = 1'b0;
    logic        busy, timed_out, acq_start;
    logic [31:0] irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic seen;

    always #5 clk = ~clk;

    acq_trig_ctrl u_acq_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
        .dig_in(dig_in), .busy(busy), .timed_out(timed_out),
        .acq_start(acq_start), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [1:0]  tt;
        logic        pol;
        logic [15:0] lvl;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [15:0] s0;
        logic [15:0] s1;
        logic [15:0] s2;
        logic        exp_fire;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 16'd100, 16'd0,  16'd0,  16'd50,  16'd150, 16'd160, 1'b1}, // R3 rise
        '{2'd0, 1'b0, 16'd100, 16'd0,  16'd0,  16'd150, 16'd50,  16'd60,  1'b0}, // R3 wrong dir
        '{2'd0, 1'b1, 16'd100, 16'd0,  16'd0,  16'd150, 16'd50,  16'd40,  1'b1}, // R4 fall
        '{2'd0, 1'b0, 16'd100, 16'd0,  16'd0,  16'd100, 16'd150, 16'd160, 1'b0}, // R3 equal level
        '{2'd0, 1'b0, 16'd100, 16'd0,  16'd0,  16'd150, 16'd160, 16'd170, 1'b0}, // R5 first above
        '{2'd1, 1'b0, 16'd0,   16'd10, 16'd20, 16'd5,   16'd15,  16'd30,  1'b1}, // R6 inside
        '{2'd1, 1'b0, 16'd0,   16'd10, 16'd20, 16'd10,  16'd20,  16'd25,  1'b0}, // R6 strict
        '{2'd1, 1'b0, 16'd0,   16'd20, 16'd10, 16'd15,  16'd15,  16'd15,  1'b0}, // R6 inverted
        '{2'd2, 1'b0, 16'd100, 16'd0,  16'd0,  16'd50,  16'd150, 16'd50,  1'b0}, // R8 digital sel
        '{2'd3, 1'b0, 16'd100, 16'd0,  16'd0,  16'd50,  16'd150, 16'd160, 1'b0}  // R2 code 3
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] v);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
        if (acq_start) seen = 1'b1;
    endtask

    function automatic logic [31:0] ctl(input logic [1:0] tt, input logic pol,
                                        input logic irq, input logic [4:0] sel);
        return {23'd0, sel, irq, pol, tt};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !acq_start && !timed_out && irq_o == 0, "R1 reset",
            {busy, acq_start, timed_out}, 0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, ctl(VEC[i].tt, VEC[i].pol, 1'b0, 5'd0));
            wr(A_LEVEL, {16'd0, VEC[i].lvl});
            wr(A_WLO, {16'd0, VEC[i].lo});
            wr(A_WHI, {16'd0, VEC[i].hi});
            wr(A_TMO, 32'd0);
            wr(A_CMD, 32'd1);
            seen = 1'b0;
            send(VEC[i].s0); send(VEC[i].s1); send(VEC[i].s2);
            chk(seen == VEC[i].exp_fire, $sformatf("R3-R8 vector %0d fire", i),
                seen, VEC[i].exp_fire);
            chk(busy == !VEC[i].exp_fire, $sformatf("R2 vector %0d busy", i),
                busy, !VEC[i].exp_fire);
        end

        // R8: invalid samples ignored
        wr(A_CTRL, ctl(2'd0, 1'b0, 1'b0, 5'd0));
        wr(A_LEVEL, 32'd100);
        wr(A_CMD, 32'd1);
        seen = 1'b0;
        send(16'd50);
        smp_data = 16'd150;
        @(negedge clk);
        if (acq_start) seen = 1'b1;
        chk(!seen && busy, "R8 invalid sample ignored", seen, 0);
        send(16'd150);
        chk(seen, "R8 valid sample fires", seen, 1);
        // R10: pulse lasts one cycle
        @(negedge clk);
        chk(!acq_start, "R10 single pulse", acq_start, 0);

        // R7: digital rising edge latency
        wr(A_CTRL, ctl(2'd2, 1'b0, 1'b0, 5'd0));
        wr(A_CMD, 32'd1);
        dig_in = 1'b1;
        @(negedge clk);
        chk(!acq_start, "R7 not after edge 1", acq_start, 0);
        @(negedge clk);
        chk(!acq_start, "R7 not after edge 2", acq_start, 0);
        @(negedge clk);
        chk(acq_start, "R7 start after edge 3", acq_start, 1);
        // R7: falling direction
        wr(A_CTRL, ctl(2'd2, 1'b1, 1'b0, 5'd0));
        wr(A_CMD, 32'd1);
        dig_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(acq_start, "R7 falling start after edge 3", acq_start, 1);

        // R9: timeout of 5 cycles
        wr(A_CTRL, ctl(2'd1, 1'b0, 1'b0, 5'd0));
        wr(A_WLO, 32'd20);
        wr(A_WHI, 32'd10);
        wr(A_TMO, 32'd5);
        wr(A_CMD, 32'd1);
        seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(busy, "R9 still waiting", busy, 1);
            @(negedge clk);
            if (acq_start) seen = 1'b1;
        end
        chk(busy && !timed_out, "R9 waiting at cycle 4", {busy, timed_out}, 2);
        @(negedge clk);
        if (acq_start) seen = 1'b1;
        chk(!busy && timed_out && !seen, "R9 expiry at cycle 5",
            {busy, timed_out, seen}, 3'b010);

        // R9: zero timeout waits forever
        wr(A_TMO, 32'd0);
        wr(A_CMD, 32'd1);
        chk(!timed_out, "R9 arm clears flag", timed_out, 0);
        repeat (60) @(negedge clk);
        chk(busy && !timed_out, "R9 zero waits forever", {busy, timed_out}, 2);

        // R10: trigger wins a tie with expiry
        wr(A_CTRL, ctl(2'd0, 1'b0, 1'b0, 5'd0));
        wr(A_TMO, 32'd3);
        wr(A_CMD, 32'd1);
        seen = 1'b0;
        send(16'd50); send(16'd60); send(16'd150);
        chk(seen && !timed_out && !busy, "R10 tie goes to trigger",
            {seen, timed_out, busy}, 3'b100);

        // R11: interrupt action
        wr(A_TMO, 32'd0);
        wr(A_CTRL, ctl(2'd0, 1'b0, 1'b1, 5'd7));
        wr(A_CMD, 32'd1);
        send(16'd50); send(16'd150);
        chk(irq_o == 32'h80, "R11 line 7 set", irq_o, 32'h80);
        repeat (10) @(negedge clk);
        chk(irq_o == 32'h80, "R11 line 7 held", irq_o, 32'h80);
        wr(A_CTRL, ctl(2'd0, 1'b0, 1'b1, 5'd31));
        wr(A_CMD, 32'd1);
        send(16'd50); send(16'd150);
        chk(irq_o == 32'h80000080, "R11 line 31 added", irq_o, 32'h80000080);
        wr(A_CTRL, ctl(2'd0, 1'b0, 1'b0, 5'd3));
        wr(A_CMD, 32'd1);
        seen = 1'b0;
        send(16'd50); send(16'd150);
        chk(seen && irq_o == 32'h80000080, "R11 action none", irq_o, 32'h80000080);
        wr(A_CMD, 32'd2);
        chk(irq_o == 0, "R11 clear command", irq_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule